// File: doc/BRIEF.md
# Trap Vector and Routing Generator

This block decides where a trap is taken and where its handler starts. On each request it looks at the current trap level, the trap type and the privilege state of the thread: a hyper-privileged bit, a privileged bit and the reset/error (RED) flag. From these it picks one of four routes: the fixed reset vector, an error condition, the hyper-privileged trap table or the privileged trap table.

For every route except the error route it forms the handler PC from the matching base register and the trap type. The next PC is always four bytes further on. It also reports the trap type the entry logic must save. On two paths this type is replaced by a fixed code.

The outputs are registered one cycle after a request strobe. A one-cycle valid pulse comes with them, or an error pulse when the error route is chosen. Saving the machine state on trap entry is done elsewhere.

Top module: `trv_gen`

## Requirements
- R1: After reset, `vld_o` and `err_o` are 0 and `route_o`, `tt_o`, `pc_o`, `npc_o` are all 0.
- R2: Outputs update on the clock edge that samples `req_i` high. `vld_o` or `err_o` is high for exactly that one following cycle. A cycle without a request raises neither.
- R3: If `red_i` is 1, or `tl_i` equals MAX_TL-1, the route is RED (code 2) and the saved type is 5. The PC is 0xFFF0000000 ORed with ((5<<5) & 0xFF), which is 0xFFF00000A0. This check comes before all others.
- R4: Otherwise, if `tl_i` is MAX_TL or above, `err_o` pulses instead of `vld_o` and the route is 3. The saved type is `tt_i`, and `pc_o`/`npc_o` keep their previous values.
- R5: Otherwise, if `tl_i` exceeds MAX_PTL and `hpriv_i` is 0, the route is hyper (code 1) and the saved type is 2. The PC is `hba_i` with bits 13:0 cleared, ORed with 0x40.
- R6: Otherwise, if `hpriv_i` is 1, or `tt_i` is 384 or more, the route is hyper (code 1) and the saved type is `tt_i`. The PC is `hba_i` with bits 13:0 cleared, ORed with ((`tt_i`<<5) & 0x3FFF).
- R7: In every other case the route is privileged (code 0) and the saved type is `tt_i`. The PC is `tba_i` with bits 14:0 cleared, ORed with ((`tt_i`<<5) & 0x3FFF), with bit 14 set when `tl_i`+1 is greater than 1.
- R8: Whenever `vld_o` is high, `npc_o` equals `pc_o` + 4.
- R9: When `hpriv_i` is 0, the value of `priv_i` has no effect on any output. A user-level trap and a privileged-level trap both escalate to the privileged level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request strobe |
| tl_i | input | TL_W | Current trap level |
| tt_i | input | TT_W | Trap type |
| hpriv_i | input | 1 | Current hyper-privileged bit |
| priv_i | input | 1 | Current privileged bit |
| red_i | input | 1 | RED flag |
| hba_i | input | ADDR_W | Hyper trap table base |
| tba_i | input | ADDR_W | Privileged trap table base |
| vld_o | output | 1 | Vector valid pulse |
| err_o | output | 1 | Error route pulse |
| route_o | output | 2 | Route: 0 privileged, 1 hyper, 2 RED, 3 error |
| tt_o | output | TT_W | Trap type to save |
| pc_o | output | ADDR_W | Handler PC |
| npc_o | output | ADDR_W | Handler next PC |

## Verification
Requests are issued at each trap-level threshold: levels 0 and 1, which separate bit 14 of the privileged vector; MAX_PTL and MAX_PTL+1, which separate the privileged and watchdog routes; MAX_TL-1; MAX_TL; and a level above MAX_TL. Types 383 and 384 bracket the cutoff to the hyper table. The same level is tried with hyper privilege off and on, which shows whether the watchdog substitution depends on privilege. The RED flag is raised at a low level to show it takes priority. User and privileged requests with identical inputs are compared to show the privileged bit is ignored. Between two valid vectors an error request shows that the PC is held.

// File: rtl/trv_pkg.sv
// Shared types for the trap vector generator.
package trv_pkg;
    typedef enum logic [1:0] {
        RT_PRIV  = 2'd0,
        RT_HYPER = 2'd1,
        RT_RED   = 2'd2,
        RT_ERR   = 2'd3
    } route_t;

    typedef enum logic [1:0] {
        LV_USER  = 2'd0,
        LV_PRIV  = 2'd1,
        LV_HYPER = 2'd2
    } level_t;
endpackage

// File: rtl/trv_route_sel.sv
// Route selector: classifies the trap into a route and picks the vector
// type. Purely combinational. Assumes MAX_PTL < MAX_TL-1.
module trv_route_sel
    import trv_pkg::*;
#(
    parameter int TL_W    = 3,
    parameter int TT_W    = 9,
    parameter int MAX_TL  = 6,
    parameter int MAX_PTL = 2,
    parameter int HYP_CUT = 384
) (
    input  logic [TL_W-1:0] tl_i,
    input  logic [TT_W-1:0] tt_i,
    input  logic            hpriv_i,
    input  logic            priv_i,
    input  logic            red_i,
    output route_t          route_o,
    output logic [TT_W-1:0] vtt_o
);
    localparam logic [TL_W-1:0] TL_RED  = TL_W'(MAX_TL - 1);
    localparam logic [TL_W-1:0] TL_ERR  = TL_W'(MAX_TL);
    localparam logic [TL_W-1:0] TL_PMAX = TL_W'(MAX_PTL);
    localparam logic [TT_W-1:0] TT_CUT  = TT_W'(HYP_CUT);
    localparam logic [TT_W-1:0] TT_REDV = TT_W'(5);
    localparam logic [TT_W-1:0] TT_WDOG = TT_W'(2);

    level_t cur_lvl;
    level_t nxt_lvl;

    // Current privilege level from the two state bits.
    always_comb begin
        if (hpriv_i)     cur_lvl = LV_HYPER;
        else if (priv_i) cur_lvl = LV_PRIV;
        else             cur_lvl = LV_USER;
    end

    // Level the trap is taken at: user escalates, others stay.
    always_comb begin
        case (cur_lvl)
            LV_HYPER: nxt_lvl = LV_HYPER;
            default:  nxt_lvl = LV_PRIV;
        endcase
    end

    // Prioritised route decision and vector type substitution.
    always_comb begin
        route_o = RT_PRIV;
        vtt_o   = tt_i;
        if (red_i || tl_i == TL_RED) begin
            route_o = RT_RED;
            vtt_o   = TT_REDV;
        end else if (tl_i >= TL_ERR) begin
            route_o = RT_ERR;
        end else if (tl_i > TL_PMAX && nxt_lvl == LV_PRIV) begin
            route_o = RT_HYPER;
            vtt_o   = TT_WDOG;
        end else if (nxt_lvl == LV_HYPER || tt_i >= TT_CUT) begin
            route_o = RT_HYPER;
        end
    end
endmodule

// File: rtl/trv_vector_gen.sv
// Vector former: builds the handler PC for the chosen route from the base
// registers and vector type. Error route yields zero (not used by the top).
module trv_vector_gen
    import trv_pkg::*;
#(
    parameter int          ADDR_W   = 64,
    parameter int          TL_W     = 3,
    parameter int          TT_W     = 9,
    parameter int          HOFF_W   = 14,
    parameter logic [63:0] RED_BASE = 64'h0000_00FF_F000_0000
) (
    input  route_t            route_i,
    input  logic [TT_W-1:0]   vtt_i,
    input  logic [TL_W-1:0]   tl_i,
    input  logic [ADDR_W-1:0] hba_i,
    input  logic [ADDR_W-1:0] tba_i,
    output logic [ADDR_W-1:0] pc_o
);
    localparam logic [ADDR_W-1:0] HMASK = (ADDR_W'(1) << HOFF_W) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PMASK = (ADDR_W'(1) << (HOFF_W + 1)) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] RMASK = ADDR_W'(8'hFF);
    localparam logic [ADDR_W-1:0] LVBIT = ADDR_W'(1) << HOFF_W;

    logic [ADDR_W-1:0] tt_sh;
    logic [ADDR_W-1:0] red_pc;
    logic [ADDR_W-1:0] hyp_pc;
    logic [ADDR_W-1:0] prv_pc;

    // Shifted type and the three candidate vectors.
    always_comb begin
        tt_sh  = ADDR_W'(vtt_i) << 5;
        red_pc = ADDR_W'(RED_BASE) | (tt_sh & RMASK);
        hyp_pc = (hba_i & ~HMASK) | (tt_sh & HMASK);
        prv_pc = (tba_i & ~PMASK) | (tt_sh & HMASK)
               | ((tl_i != '0) ? LVBIT : '0);
    end

    // Select the vector by route.
    always_comb begin
        case (route_i)
            RT_RED:   pc_o = red_pc;
            RT_HYPER: pc_o = hyp_pc;
            RT_PRIV:  pc_o = prv_pc;
            default:  pc_o = '0;
        endcase
    end
endmodule

// File: rtl/trv_gen.sv
// Trap vector and routing generator top. Registers route, saved type and
// handler PC/NPC on a request strobe; pulses valid or error for one cycle.
// Assumes inputs are stable in the cycle req_i is high.
module trv_gen
    import trv_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int TL_W    = 3,
    parameter int TT_W    = 9,
    parameter int MAX_TL  = 6,
    parameter int MAX_PTL = 2,
    parameter int HYP_CUT = 384,
    parameter int INSN_B  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [TL_W-1:0]   tl_i,
    input  logic [TT_W-1:0]   tt_i,
    input  logic              hpriv_i,
    input  logic              priv_i,
    input  logic              red_i,
    input  logic [ADDR_W-1:0] hba_i,
    input  logic [ADDR_W-1:0] tba_i,
    output logic              vld_o,
    output logic              err_o,
    output logic [1:0]        route_o,
    output logic [TT_W-1:0]   tt_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] npc_o
);
    route_t            sel_route;
    logic [TT_W-1:0]   sel_tt;
    logic [ADDR_W-1:0] sel_pc;

    trv_route_sel #(
        .TL_W(TL_W), .TT_W(TT_W), .MAX_TL(MAX_TL),
        .MAX_PTL(MAX_PTL), .HYP_CUT(HYP_CUT)
    ) u_sel (
        .tl_i(tl_i), .tt_i(tt_i), .hpriv_i(hpriv_i), .priv_i(priv_i),
        .red_i(red_i), .route_o(sel_route), .vtt_o(sel_tt)
    );

    trv_vector_gen #(
        .ADDR_W(ADDR_W), .TL_W(TL_W), .TT_W(TT_W)
    ) u_vec (
        .route_i(sel_route), .vtt_i(sel_tt), .tl_i(tl_i),
        .hba_i(hba_i), .tba_i(tba_i), .pc_o(sel_pc)
    );

    // Output register: capture on request, hold PC on the error route.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o   <= 1'b0;
            err_o   <= 1'b0;
            route_o <= '0;
            tt_o    <= '0;
            pc_o    <= '0;
            npc_o   <= '0;
        end else begin
            vld_o <= req_i && (sel_route != RT_ERR);
            err_o <= req_i && (sel_route == RT_ERR);
            if (req_i) begin
                route_o <= sel_route;
                tt_o    <= sel_tt;
                if (sel_route != RT_ERR) begin
                    pc_o  <= sel_pc;
                    npc_o <= sel_pc + ADDR_W'(INSN_B);
                end
            end
        end
    end
endmodule

// File: rtl/trv_gen_chk.sv
// Checker for trv_gen: port-level temporal properties, bound to the top.
module trv_gen_chk #(
    parameter int ADDR_W = 64,
    parameter int TT_W   = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              red_i,
    input logic              vld_o,
    input logic              err_o,
    input logic [1:0]        route_o,
    input logic [TT_W-1:0]   tt_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] npc_o
);
    AST_NO_REQ_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!vld_o && !err_o)); // R2
    AST_REQ_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (vld_o != err_o)); // R2
    AST_RED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && red_i) |=> (vld_o && route_o == 2'd2 && tt_o == TT_W'(5))); // R3
    AST_ERR_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($stable(pc_o) && $stable(npc_o) && route_o == 2'd3)); // R4
    AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (npc_o == pc_o + ADDR_W'(4))); // R8
endmodule

bind trv_gen trv_gen_chk #(.ADDR_W(ADDR_W), .TT_W(TT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .red_i(red_i),
    .vld_o(vld_o), .err_o(err_o), .route_o(route_o), .tt_o(tt_o),
    .pc_o(pc_o), .npc_o(npc_o)
);

// File: tb/trv_gen_bench.sv
module trv_gen_bench;
    localparam int AW = 64;
    localparam int TLW = 3;
    localparam int TTW = 9;
    localparam int MTL = 6;
    localparam int MPTL = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req = 1'b0;
    logic [TLW-1:0] tl = '0;
    logic [TTW-1:0] tt = '0;
    logic           hp = 1'b0, pv = 1'b0, rd = 1'b0;
    logic [AW-1:0]  hba = 64'hFEDC_BA98_7654_3210;
    logic [AW-1:0]  tba = 64'h1234_5678_9ABC_DEF0;
    logic           vld, err;
    logic [1:0]     route;
    logic [TTW-1:0] tto;
    logic [AW-1:0]  pc, npc;

    int n_chk = 0;
    int n_fail = 0;

    trv_gen u_trv_gen (
        .clk(clk), .rst_n(rst_n), .req_i(req), .tl_i(tl), .tt_i(tt),
        .hpriv_i(hp), .priv_i(pv), .red_i(rd), .hba_i(hba), .tba_i(tba),
        .vld_o(vld), .err_o(err), .route_o(route), .tt_o(tto),
        .pc_o(pc), .npc_o(npc)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req_tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    // Issue one request; after it, outputs are sampled at the next negedge.
    task automatic issue(input int l, input int t, input logic h, input logic p, input logic r);
        @(negedge clk);
        tl = TLW'(l); tt = TTW'(t); hp = h; pv = p; rd = r; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic expect_vec(input string tag, input int rt, input int et, input logic [AW-1:0] epc);
        chk(tag, AW'(vld), 1);
        chk(tag, AW'(err), 0);
        chk(tag, AW'(route), AW'(rt));
        chk(tag, AW'(tto), AW'(et));
        chk(tag, pc, epc);
        chk("R8", npc, epc + 4);
    endtask

    function automatic logic [AW-1:0] hv(input int t);
        return (hba & ~64'h3FFF) | ((AW'(t) << 5) & 64'h3FFF);
    endfunction
    function automatic logic [AW-1:0] pvv(input int t, input int l);
        return (tba & ~64'h7FFF) | ((AW'(t) << 5) & 64'h3FFF) | ((l + 1 > 1) ? 64'h4000 : 64'h0);
    endfunction

    task automatic t_reset();
        chk("R1", AW'(vld), 0); chk("R1", AW'(err), 0);
        chk("R1", AW'(route), 0); chk("R1", AW'(tto), 0);
        chk("R1", pc, 0); chk("R1", npc, 0);
    endtask

    task automatic t_priv();
        issue(0, 'h24, 0, 1, 0); expect_vec("R7 tl0", 0, 'h24, pvv('h24, 0));
        @(negedge clk); chk("R2 pulse", AW'(vld), 0);
        issue(1, 'h24, 0, 1, 0); expect_vec("R7 tl1", 0, 'h24, pvv('h24, 1));
        issue(MPTL, 383, 0, 1, 0); expect_vec("R7 tt383", 0, 383, pvv(383, MPTL));
    endtask

    task automatic t_user_same();
        logic [AW-1:0] a;
        issue(2, 'h100, 0, 1, 0); a = pc;
        issue(2, 'h100, 0, 0, 0);
        expect_vec("R9 user", 0, 'h100, pvv('h100, 2));
        chk("R9 same", pc, a);
    endtask

    task automatic t_hyper();
        issue(0, 384, 0, 1, 0); expect_vec("R6 tt384", 1, 384, hv(384));
        issue(3, 'h10, 1, 0, 0); expect_vec("R6 hpriv", 1, 'h10, hv('h10));
    endtask

    task automatic t_wdog();
        issue(MPTL + 1, 'h24, 0, 1, 0); expect_vec("R5 wdog", 1, 2, hv(2));
        issue(MPTL + 1, 'h24, 0, 0, 0); expect_vec("R5 user", 1, 2, hv(2));
    endtask

    task automatic t_red();
        issue(MTL - 1, 'h24, 0, 1, 0); expect_vec("R3 tl", 2, 5, 64'hFF_F000_00A0);
        issue(0, 'h33, 1, 0, 1); expect_vec("R3 flag", 2, 5, 64'hFF_F000_00A0);
        issue(MTL, 'h33, 0, 0, 1); expect_vec("R3 prio", 2, 5, 64'hFF_F000_00A0);
    endtask

    task automatic t_err();
        logic [AW-1:0] p0;
        issue(0, 'h40, 0, 1, 0); p0 = pc;
        issue(MTL, 'h41, 0, 1, 0);
        chk("R4 err", AW'(err), 1); chk("R4 vld", AW'(vld), 0);
        chk("R4 route", AW'(route), 3); chk("R4 tt", AW'(tto), 'h41);
        chk("R4 pc", pc, p0); chk("R4 npc", npc, p0 + 4);
        @(negedge clk); chk("R2 errpulse", AW'(err), 0);
        issue(7, 'h42, 1, 0, 0);
        chk("R4 tl7", AW'(err), 1); chk("R4 pc7", pc, p0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priv();
        t_user_same();
        t_hyper();
        t_wdog();
        t_red();
        t_err();
        repeat (2) @(negedge clk);
        chk("R2 idle", AW'(vld | err), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule